// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

A bank of 32-bit system control registers, reached through a word-addressed read/write port. Most of the lower part of the map is locked until software writes a magic value to the key register at byte offset 0x00. While the bank is locked, writes into that window are silently dropped. Registers at 0x104 and above stay writable at all times.

A few registers do not behave like plain storage. The strap register is set by writes to its own offset and cleared by writes to the revision offset, and the revision value itself never changes. A group of status-like offsets ignores writes altogether. The random-data offset returns a new pseudo-random word on every read. Reset loads a computed default image. The revision, both strap words and the key word are then taken from input ports, which lets the integrating chip choose its own identity and strapping and decide whether the bank starts unlocked.

Reads return their data one cycle after the request. Writes take effect on the clock edge that accepts them.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, the following values read back:
  - offset 0x04 reads 0xFFCFFEDC, 0x08 reads 0xF3F40000, 0x74 reads 0x0000000E, and 0xE0 and 0xE4 read 0x000000FF;
  - unlisted offsets read 0;
  - 0x7C reads rev_i, 0x70 reads strap1_i, 0xD0 reads strap2_i, and 0x00 reads key_i;
  - rvalid_o is 0.
- R2: A write to offset 0x00 stores 1 if the data equals the MAGIC parameter (0x1688A8A8 by default) and 0 otherwise, so a wrong key relocks the bank. The bank is unlocked while that register is nonzero.
- R3: While locked, a write to any offset from 0x04 up to and including 0x100 is discarded. Offsets 0x104 and above accept writes whether the bank is locked or not.
- R4: When unlocked, a write to 0x70 ORs the data into the strap register.
- R5: When unlocked, a write to 0x7C clears the strap bits at 0x70 where the data has 1s. The revision word at 0x7C never changes after reset.
- R6: Writes to 0x14, 0x50 through 0x6C, 0x78, 0xE0 and 0xE4 are ignored even when unlocked.
- R7: Each read of 0x78 returns the current state of a 32-bit Galois LFSR and then advances it once. The LFSR shifts right and XORs 0x80200003 when the bit shifted out is 1. It starts at SEED (0x5EEDC0DE by default). The control word at 0x74 does not affect this.
- R8: A read at a byte offset of 0x1A8 or above returns 0, and a write there is ignored.
- R9: An access whose address bits [1:0] are not 00 is rejected: a write changes nothing and a read returns 0.
- R10: rvalid_o is 1 exactly in the cycle after a read request, and rdata_o is valid in that cycle. A read issued the cycle after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rev_i | input | 32 | Revision word loaded at reset |
| strap1_i | input | 32 | Strap word 1 loaded at reset |
| strap2_i | input | 32 | Strap word 2 loaded at reset |
| key_i | input | 32 | Key register value loaded at reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench probes both edges of the lock window by writing 0x100 and 0x104 while locked. A design with an off-by-one window would either corrupt 0x100 or lose 0x104. It sets and clears strap bits through the two offsets and rereads the revision word; a design that stored the clear data into the revision register would show it there. Read-only offsets are written while unlocked, and a wrong key is followed by a write that must be dropped. The random offset is read several times before and after the control word at 0x74 is cleared, and a design that skipped or repeated an LFSR step would break the computed sequence. Misaligned and out-of-range writes are each followed by a read of the aligned neighbour, to catch decodes that drop the low address bits or wrap the index.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int          IDX_KEY      = 0;
  localparam int          IDX_FEVAL    = 5;
  localparam int          IDX_SCR_LO   = 20;
  localparam int          IDX_SCR_HI   = 27;
  localparam int          IDX_STRAP1   = 28;
  localparam int          IDX_RNG      = 30;
  localparam int          IDX_REV      = 31;
  localparam int          IDX_STRAP2   = 52;
  localparam int          IDX_FCNT0    = 56;
  localparam int          IDX_FCNT1    = 57;
  localparam int          IDX_LOCK_END = 65;  // first index outside the lock window
  localparam logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003;

  typedef enum logic [2:0] {
    WK_NONE, WK_PLAIN, WK_KEY, WK_SET, WK_CLR
  } wr_kind_e;

  function automatic logic [DATA_W-1:0] reg_default(int idx);
    case (idx)
      1:         reg_default = 32'hFFCF_FEDC;
      2:         reg_default = 32'hF3F4_0000;
      29:        reg_default = 32'h0000_000E;
      IDX_FCNT0,
      IDX_FCNT1: reg_default = 32'h0000_00FF;
      default:   reg_default = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lfsr_next(logic [DATA_W-1:0] s);
    lfsr_next = s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 106,
  parameter int unsigned ADDR_W   = 12,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              key_open_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output wr_kind_e          wr_kind_o
);
  logic [ADDR_W-3:0] widx;
  logic aligned, in_range, ro;
  int   idx_n;

  assign widx     = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_range = (int'(widx) < int'(NUM_REGS));
  assign hit_o    = aligned && in_range;
  assign idx_o    = widx[IDX_W-1:0];
  assign idx_n    = int'(idx_o);

  assign ro = (idx_n == IDX_FEVAL) || (idx_n == IDX_RNG) ||
              (idx_n >= IDX_SCR_LO && idx_n <= IDX_SCR_HI) ||
              (idx_n == IDX_FCNT0) || (idx_n == IDX_FCNT1);

  always_comb begin
    wr_kind_o = WK_NONE;
    if (req_i && we_i && hit_o) begin
      if (idx_n == IDX_KEY)                         wr_kind_o = WK_KEY;
      else if (!key_open_i && idx_n < IDX_LOCK_END) wr_kind_o = WK_NONE;
      else if (idx_n == IDX_STRAP1)                 wr_kind_o = WK_SET;
      else if (idx_n == IDX_REV)                    wr_kind_o = WK_CLR;
      else if (ro)                                  wr_kind_o = WK_NONE;
      else                                          wr_kind_o = WK_PLAIN;
    end
  end
endmodule

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] SEED = 32'h5EED_C0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [DATA_W-1:0] state_o
);
  logic [DATA_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= lfsr_next(state_q);
  end
  assign state_o = state_q;

  p_lfsr_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_lfsr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned       NUM_REGS = 106,
  parameter logic [DATA_W-1:0] MAGIC    = 32'h1688_A8A8,
  localparam int unsigned      IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rev_i,
  input  logic [DATA_W-1:0] strap1_i,
  input  logic [DATA_W-1:0] strap2_i,
  input  logic [DATA_W-1:0] key_i,
  input  wr_kind_e          wr_kind_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              key_open_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_REGS); i++) regs_q[i] <= reg_default(i);
      regs_q[IDX_REV]    <= rev_i;
      regs_q[IDX_STRAP1] <= strap1_i;
      regs_q[IDX_STRAP2] <= strap2_i;
      regs_q[IDX_KEY]    <= key_i;
    end else begin
      case (wr_kind_i)
        WK_PLAIN: regs_q[widx_i]     <= wdata_i;
        WK_KEY:   regs_q[IDX_KEY]    <= (wdata_i == MAGIC) ? 32'd1 : 32'd0;
        WK_SET:   regs_q[IDX_STRAP1] <= regs_q[IDX_STRAP1] | wdata_i;
        WK_CLR:   regs_q[IDX_STRAP1] <= regs_q[IDX_STRAP1] & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign rdata_o    = (int'(ridx_i) < int'(NUM_REGS)) ? regs_q[ridx_i] : '0;
  assign key_open_o = |regs_q[IDX_KEY];

  p_key_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i == WK_KEY) |=>
      regs_q[IDX_KEY] == (($past(wdata_i) == MAGIC) ? 32'd1 : 32'd0));
  p_strap_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i == WK_SET) |=>
      ((regs_q[IDX_STRAP1] & $past(wdata_i)) == $past(wdata_i)));
  p_strap_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i == WK_CLR) |=> ((regs_q[IDX_STRAP1] & $past(wdata_i)) == '0));
  p_rev_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(regs_q[IDX_REV]));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned       NUM_REGS = 106,
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [DATA_W-1:0] MAGIC    = 32'h1688_A8A8,
  parameter logic [DATA_W-1:0] SEED     = 32'h5EED_C0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       rev_i,
  input  logic [31:0]       strap1_i,
  input  logic [31:0]       strap2_i,
  input  logic [31:0]       key_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic              hit, key_open, rd_hit, rng_rd;
  logic [IDX_W-1:0]  idx;
  wr_kind_e          wr_kind;
  logic [DATA_W-1:0] reg_rdata, rng_state, rdata_q;
  logic              rvalid_q;

  sysctl_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .key_open_i(key_open),
    .hit_o(hit), .idx_o(idx), .wr_kind_o(wr_kind)
  );

  sysctl_regfile #(.NUM_REGS(NUM_REGS), .MAGIC(MAGIC)) u_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rev_i(rev_i), .strap1_i(strap1_i), .strap2_i(strap2_i), .key_i(key_i),
    .wr_kind_i(wr_kind), .widx_i(idx), .wdata_i(wdata_i),
    .ridx_i(idx), .rdata_o(reg_rdata), .key_open_o(key_open)
  );

  assign rd_hit = req_i && !we_i && hit;
  assign rng_rd = rd_hit && (int'(idx) == IDX_RNG);

  sysctl_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rng_rd), .state_o(rng_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i)
        rdata_q <= !rd_hit ? '0 : (rng_rd ? rng_state : reg_rdata);
    end
  end
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  p_rvalid_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  // also covers R9: misaligned reads are not hits
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |=> (rdata_o == '0));
  p_lock_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_open && req_i && we_i && hit && int'(idx) > IDX_KEY &&
     int'(idx) < IDX_LOCK_END) |-> (wr_kind == WK_NONE));
endmodule

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;
  localparam int CLK_P = 10;
  localparam logic [31:0] MAGIC = 32'h1688_A8A8;
  localparam logic [31:0] SEED  = 32'h5EED_C0DE;
  localparam logic [31:0] REV   = 32'h0A0B_0C0D;
  localparam logic [31:0] ST1   = 32'h00F0_0F00;
  localparam logic [31:0] ST2   = 32'h1234_5678;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rvalid;
  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;
  logic [31:0] rng_exp = SEED;
  logic [31:0] strap_exp = ST1;
  logic [31:0] rd;

  always #(CLK_P/2) clk = ~clk;

  sysctl_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .rev_i(REV), .strap1_i(ST1), .strap2_i(ST2),
    .key_i(32'h0), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [31:0] model_step(logic [31:0] s);
    logic [31:0] t = {1'b0, s[31:1]};
    if (s[0]) t = t ^ 32'h8020_0003;
    return t;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rdw(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; req = 0;
    if (rvalid !== 1'b1) begin n_fail++; $display("FAIL R10: rvalid low on read"); end
  endtask

  task automatic t_reset;
    chk("R1 rvalid", {31'b0, rvalid}, 32'h0);
    rdw(12'h000, rd); chk("R1 key", rd, 32'h0);
    rdw(12'h004, rd); chk("R1 dflt04", rd, 32'hFFCF_FEDC);
    rdw(12'h008, rd); chk("R1 dflt08", rd, 32'hF3F4_0000);
    rdw(12'h074, rd); chk("R1 dflt74", rd, 32'h0000_000E);
    rdw(12'h0E4, rd); chk("R1 dfltE4", rd, 32'h0000_00FF);
    rdw(12'h010, rd); chk("R1 zero", rd, 32'h0);
    rdw(12'h07C, rd); chk("R1 rev", rd, REV);
    rdw(12'h070, rd); chk("R1 strap1", rd, ST1);
    rdw(12'h0D0, rd); chk("R1 strap2", rd, ST2);
  endtask

  task automatic t_locked;
    wr(12'h004, 32'h1111_1111); rdw(12'h004, rd); chk("R3 locked 04", rd, 32'hFFCF_FEDC);
    wr(12'h100, 32'h2222_2222); rdw(12'h100, rd); chk("R3 locked 100", rd, 32'h0);
    wr(12'h104, 32'h0000_CAFE); rdw(12'h104, rd); chk("R3 open 104", rd, 32'h0000_CAFE);
    wr(12'h070, 32'hFFFF_FFFF); rdw(12'h070, rd); chk("R3 locked strap", rd, ST1);
  endtask

  task automatic t_key;
    wr(12'h000, MAGIC); rdw(12'h000, rd); chk("R2 magic", rd, 32'h1);
    wr(12'h004, 32'h1111_1111); rdw(12'h004, rd); chk("R2 unlocked 04", rd, 32'h1111_1111);
    wr(12'h100, 32'h2222_2222); rdw(12'h100, rd); chk("R3 unlocked 100", rd, 32'h2222_2222);
  endtask

  task automatic t_strap;
    wr(12'h070, 32'h0000_00FF); strap_exp = strap_exp | 32'h0000_00FF;
    rdw(12'h070, rd); chk("R4 strap set", rd, strap_exp);
    wr(12'h07C, 32'h00F0_000F); strap_exp = strap_exp & ~32'h00F0_000F;
    rdw(12'h070, rd); chk("R5 strap clr", rd, strap_exp);
    rdw(12'h07C, rd); chk("R5 rev kept", rd, REV);
  endtask

  task automatic t_ro;
    wr(12'h014, 32'hA5A5_A5A5); rdw(12'h014, rd); chk("R6 ro 14", rd, 32'h0);
    wr(12'h050, 32'hA5A5_A5A5); rdw(12'h050, rd); chk("R6 ro 50", rd, 32'h0);
    wr(12'h06C, 32'hA5A5_A5A5); rdw(12'h06C, rd); chk("R6 ro 6C", rd, 32'h0);
    wr(12'h0E0, 32'hA5A5_A5A5); rdw(12'h0E0, rd); chk("R6 ro E0", rd, 32'h0000_00FF);
    wr(12'h078, 32'hA5A5_A5A5);  // must not disturb the sequence, checked in t_rng
  endtask

  task automatic t_rng;
    for (int i = 0; i < 3; i++) begin
      rdw(12'h078, rd); chk("R7 rng", rd, rng_exp); rng_exp = model_step(rng_exp);
    end
    wr(12'h074, 32'h0); rdw(12'h074, rd); chk("R7 ctl clear", rd, 32'h0);
    for (int i = 0; i < 2; i++) begin
      rdw(12'h078, rd); chk("R7 rng ctl off", rd, rng_exp); rng_exp = model_step(rng_exp);
    end
  endtask

  task automatic t_oob;
    rdw(12'h1A8, rd); chk("R8 oob rd", rd, 32'h0);
    wr(12'h1A8, 32'h7777_7777); rdw(12'h1A8, rd); chk("R8 oob wr", rd, 32'h0);
    rdw(12'hFFC, rd); chk("R8 top rd", rd, 32'h0);
    rdw(12'h000, rd); chk("R8 no alias", rd, 32'h1);
  endtask

  task automatic t_misalign;
    wr(12'h106, 32'hDEAD_0000); rdw(12'h104, rd); chk("R9 mis wr", rd, 32'h0000_CAFE);
    rdw(12'h105, rd); chk("R9 mis rd", rd, 32'h0);
  endtask

  task automatic t_latency;
    wr(12'h108, 32'h0BAD_F00D);
    @(negedge clk); req = 1; we = 0; addr = 12'h108;
    @(negedge clk); req = 0;
    chk("R10 rvalid", {31'b0, rvalid}, 32'h1);
    chk("R10 data", rdata, 32'h0BAD_F00D);
    @(negedge clk); chk("R10 rvalid drop", {31'b0, rvalid}, 32'h0);
  endtask

  task automatic t_relock;
    wr(12'h000, 32'h0000_0001); rdw(12'h000, rd); chk("R2 wrong key", rd, 32'h0);
    wr(12'h008, 32'h3333_3333); rdw(12'h008, rd); chk("R2 relocked", rd, 32'hF3F4_0000);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_key();
    t_strap();
    t_ro();
    t_rng();
    t_oob();
    t_misalign();
    t_latency();
    t_relock();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule